// File: doc/BRIEF.md
# Dual-Channel Double-Buffered CODEC Serial Port

This block connects a processor register bus to an external audio CODEC over a full-duplex synchronous serial link. It has two channels. Each carries 16-bit samples, and each has one data address that hides two registers. A bus write to that address fills the channel's transmit holding register. A bus read from the same address returns the last completely received word. A third address holds the per-channel enables and the receive-ready flags.

The serial side is a slave. The CODEC, or some other master, supplies the bit clock `sclk` and one frame-sync line per channel. Each word is enclosed by its frame sync, and all serial timing follows `sclk` and the frame syncs alone, independent of the processor clock. Both channels share a single transmit line and a single receive line, and the channel whose frame sync is high owns the link. Each received word crosses into the processor clock domain with a toggle handshake through two-flop synchronizers. The enables cross the other way the same way.

The bus is a plain register interface and has no back-pressure. A write always lands in the holding register. Software should write the holding register between that channel's frames, because the serial side copies it at frame start without any handshake. A new received word overwrites an unread one.

Top module: `dual_codec_port`

## Requirements
- R1: After reset, reads of every address return 0, all ready flags and enables are 0, and `txd` is 0.
- R2: A write to a channel data address (0 = channel 0, 1 = channel 1) stores the transmit holding register only. A read of that address returns the channel's receive buffer, not the written value.
- R3: On the first rising `sclk` edge at which an enabled channel's frame sync is high after being low, the holding register is copied into the transmit shifter. `txd` then presents the word MSB first, one bit after each rising edge, for 16 bits.
- R4: While an enabled channel's frame sync is high, `rxd` is sampled on each falling `sclk` edge, MSB first. The 16th sample completes the word.
- R5: A word completes only if frame sync stays high for all 16 falling edges. A frame that ends early is discarded and leaves the buffer and the ready flag unchanged.
- R6: For a channel whose enable is 0, a frame drives `txd` to 0 throughout and captures no word.
- R7: A completed word is copied into the channel's receive buffer in the processor domain, and the channel's ready flag is set.
- R8: A bus read (`bus_rd` high) of a channel data address clears that channel's ready flag. The buffer keeps its value until the next completed word.
- R9: If the holding register is not rewritten, the next frame transmits the same word again.
- R10: The channels are independent. Channel 1 uses frame sync bit 1, its own holding register and its own buffer. A channel-1 frame leaves channel 0's buffer unchanged. `txd` is 0 when no frame sync is high.
- R11: Control address 2 holds enable bits [1:0] (bit c enables channel c) and reads back as {ready1, ready0, en1, en0} in bits [3:0], with the upper bits 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | 2 | Register address: 0 ch0 data, 1 ch1 data, 2 control |
| bus_wr | input | 1 | Write strobe, sampled on `clk` |
| bus_rd | input | 1 | Read strobe; a read of a data address clears its ready flag |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| sclk | input | 1 | External serial bit clock |
| fsync | input | 2 | Frame sync per channel, bit c for channel c |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |

## Verification
The assertions watch the following on every cycle:
- the transmit shifter loads the holding register at each frame start;
- a receive toggle occurs only inside an enabled frame;
- ready rises after each word hand-off and falls after a read;
- the buffer and holding registers change only on a new word or a write;
- the two frame syncs are never high together.

The MSB-first bit order on both lines needs the bench's scenarios. So do truncated frames that must be dropped, a disabled channel's silence, reuse of a stale holding word, and the separation between channels. The bench covers these with a walking-one sweep on channel 0, arithmetic word sequences on channel 1, and checks through the bus after every frame.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  // Bus address width needed for NUM_CH data addresses plus one control address.
  function automatic int unsigned port_addr_w(input int unsigned num_ch);
    return (num_ch + 1 <= 2) ? 1 : $clog2(num_ch + 1);
  endfunction
endpackage

// File: rtl/codec_bit_sync.sv
module codec_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/codec_ch_serial.sv
module codec_ch_serial #(
  parameter int DATA_W = 16
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              en,
  input  logic [DATA_W-1:0] hold,
  input  logic              rxd,
  output logic              tx_bit,
  output logic [DATA_W-1:0] cap,
  output logic              cap_tgl
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic              fs_q;
  logic              active;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CW-1:0]     rx_cnt;

  // Transmit side: launch on rising sclk.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      active <= 1'b0;
      tx_sh  <= '0;
    end else begin
      fs_q <= fs;
      if (fs && !fs_q) begin
        active <= en;
        tx_sh  <= hold;
      end else if (fs && active) begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end else if (!fs) begin
        active <= 1'b0;
      end
    end
  end

  assign tx_bit = fs & active & tx_sh[DATA_W-1];

  // Receive side: sample on falling sclk.
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      rx_cnt  <= '0;
      cap     <= '0;
      cap_tgl <= 1'b0;
    end else if (!fs || !active) begin
      rx_cnt <= '0;
    end else begin
      rx_sh <= {rx_sh[DATA_W-2:0], rxd};
      if (rx_cnt == LAST) begin
        cap     <= {rx_sh[DATA_W-2:0], rxd};
        cap_tgl <= ~cap_tgl;
        rx_cnt  <= '0;
      end else begin
        rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end

  AST_LOAD_AT_START: assert property (@(posedge sclk) disable iff (!rst_n)
    (fs && !fs_q && en) |=> (tx_sh == $past(hold))); // R3

  AST_CAP_ONLY_IN_FRAME: assert property (@(negedge sclk) disable iff (!rst_n)
    (cap_tgl != $past(cap_tgl)) |-> $past(fs && active)); // R5
endmodule

// File: rtl/codec_ch_host.sv
module codec_ch_host #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cap,
  input  logic              cap_tgl,
  output logic [DATA_W-1:0] hold,
  output logic [DATA_W-1:0] rx_buf,
  output logic              ready
);
  logic tgl_s;
  logic tgl_q;
  logic new_word;

  codec_bit_sync #(.W(1)) u_tgl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cap_tgl),
    .q    (tgl_s)
  );

  assign new_word = tgl_s ^ tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q  <= 1'b0;
      hold   <= '0;
      rx_buf <= '0;
      ready  <= 1'b0;
    end else begin
      tgl_q <= tgl_s;
      if (wr_hit) hold <= wdata;
      if (new_word) begin
        rx_buf <= cap;
        ready  <= 1'b1;
      end else if (rd_hit) begin
        ready <= 1'b0;
      end
    end
  end

  AST_READY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    new_word |=> ready); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !new_word) |=> !ready); // R8

  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !new_word |=> $stable(rx_buf)); // R8

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(hold)); // R9
endmodule

// File: rtl/dual_codec_port.sv
module dual_codec_port
  import codec_port_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2,
  localparam int AW    = port_addr_w(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk,
  input  logic [NUM_CH-1:0] fsync,
  input  logic              rxd,
  output logic              txd
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_CH);

  logic [NUM_CH-1:0] en;
  logic [NUM_CH-1:0] en_s;
  logic [NUM_CH-1:0] ready;
  logic [NUM_CH-1:0] tx_bit;
  logic [NUM_CH-1:0] cap_tgl;
  logic [DATA_W-1:0] hold   [NUM_CH];
  logic [DATA_W-1:0] rx_buf [NUM_CH];
  logic [DATA_W-1:0] cap    [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (bus_wr && bus_addr == CTRL_ADDR) en <= bus_wdata[NUM_CH-1:0];
  end

  codec_bit_sync #(.W(NUM_CH)) u_en_sync (
    .clk  (sclk),
    .rst_n(rst_n),
    .d    (en),
    .q    (en_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit;
    logic rd_hit;
    assign wr_hit = bus_wr && (bus_addr == AW'(c));
    assign rd_hit = bus_rd && (bus_addr == AW'(c));

    codec_ch_host #(.DATA_W(DATA_W)) u_host (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit),
      .wdata  (bus_wdata),
      .cap    (cap[c]),
      .cap_tgl(cap_tgl[c]),
      .hold   (hold[c]),
      .rx_buf (rx_buf[c]),
      .ready  (ready[c])
    );

    codec_ch_serial #(.DATA_W(DATA_W)) u_serial (
      .sclk   (sclk),
      .rst_n  (rst_n),
      .fs     (fsync[c]),
      .en     (en_s[c]),
      .hold   (hold[c]),
      .rxd    (rxd),
      .tx_bit (tx_bit[c]),
      .cap    (cap[c]),
      .cap_tgl(cap_tgl[c])
    );
  end

  assign txd = |tx_bit;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) begin
      bus_rdata[NUM_CH-1:0]        = en;
      bus_rdata[2*NUM_CH-1:NUM_CH] = ready;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == AW'(c)) bus_rdata = rx_buf[c];
      end
    end
  end

  AST_FSYNC_EXCLUSIVE: assert property (@(posedge sclk) disable iff (!rst_n)
    $onehot0(fsync)); // R10
endmodule

// File: tb/dual_codec_port_tb_top.sv
module dual_codec_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 23;
  localparam int QTR        = 11;

  logic        clk = 1'b0;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  fsync = '0;
  logic        rxd = 1'b0;
  logic        txd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SCLK_HALF) sclk = ~sclk;

  dual_codec_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .fsync(fsync), .rxd(rxd), .txd(txd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // One frame on channel ch lasting nbits rising edges; returns the txd bits seen.
  task automatic run_frame(input int ch, input logic [15:0] rx_word, input int nbits,
                           output logic [15:0] tx_seen);
    tx_seen = '0;
    @(negedge sclk);
    #QTR fsync[ch] = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(posedge sclk);
      #QTR;
      rxd = rx_word[15-i];
      tx_seen[15-i] = txd;
    end
    @(negedge sclk);
    #QTR fsync[ch] = 1'b0;
    rxd = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, seen, tx, rx, last0, last1, ltx1;
    repeat (4) @(posedge clk);
    #1 check("R1 txd", {15'b0, txd}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      bus_peek(2'(a), v);
      check("R1 reset read", v, 16'h0);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    bus_peek(2'd3, v);
    check("R11 addr3 reads zero", v, 16'h0);
    bus_write(2'd2, 16'h0003);
    bus_peek(2'd2, v);
    check("R11 enables readback", v, 16'h0003);
    repeat (4) @(posedge sclk);

    // Channel 0 walking-one sweep.
    last0 = '0;
    for (int k = 0; k < 16; k++) begin
      tx = 16'h1 << k;
      rx = ~tx ^ 16'(k * 16'h0101);
      bus_write(2'd0, tx);
      bus_peek(2'd0, v);
      check("R2 read gives buffer", v, last0);
      run_frame(0, rx, 16, seen);
      check("R3 tx MSB first", seen, tx);
      bus_peek(2'd2, v);
      check("R7 ready0 set", v, 16'h0007);
      bus_read(2'd0, v);
      check("R4 rx word", v, rx);
      bus_peek(2'd2, v);
      check("R8 ready0 cleared", v, 16'h0003);
      bus_peek(2'd0, v);
      check("R8 buffer kept", v, rx);
      last0 = rx;
    end

    // Channel 1 arithmetic sequence.
    last1 = '0;
    for (int k = 0; k < 8; k++) begin
      tx = 16'(k * 16'h2B3D + 16'h1111);
      rx = 16'(16'hA5A5 ^ (k * 16'h3C71));
      bus_write(2'd1, tx);
      run_frame(1, rx, 16, seen);
      check("R10 ch1 tx", seen, tx);
      bus_peek(2'd2, v);
      check("R10 ready1 only", v, 16'h000B);
      bus_peek(2'd0, v);
      check("R10 ch0 buffer untouched", v, last0);
      bus_read(2'd1, v);
      check("R10 ch1 rx", v, rx);
      last1 = rx;
      ltx1 = tx;
    end

    // Holding register reused.
    run_frame(1, 16'h0F0F, 16, seen);
    check("R9 stale word resent", seen, ltx1);
    bus_read(2'd1, v);
    check("R9 rx with stale tx", v, 16'h0F0F);
    last1 = 16'h0F0F;

    // Truncated frame dropped, then a full frame succeeds.
    bus_write(2'd0, 16'hC3A5);
    run_frame(0, 16'hFFFF, 10, seen);
    bus_peek(2'd2, v);
    check("R5 no ready after short frame", v, 16'h0003);
    bus_peek(2'd0, v);
    check("R5 buffer unchanged", v, last0);
    run_frame(0, 16'h5AC3, 16, seen);
    check("R5 tx after short frame", seen, 16'hC3A5);
    bus_read(2'd0, v);
    check("R5 full frame after short", v, 16'h5AC3);
    last0 = 16'h5AC3;

    // Disabled channel 0.
    bus_write(2'd2, 16'h0002);
    bus_peek(2'd2, v);
    check("R11 enable write", v, 16'h0002);
    repeat (4) @(posedge sclk);
    bus_write(2'd0, 16'hFFFF);
    run_frame(0, 16'h1234, 16, seen);
    check("R6 txd silent", seen, 16'h0000);
    bus_peek(2'd2, v);
    check("R6 no ready", v, 16'h0002);
    bus_peek(2'd0, v);
    check("R6 buffer unchanged", v, last0);
    run_frame(1, 16'h7E81, 16, seen);
    bus_read(2'd1, v);
    check("R10 ch1 still works", v, 16'h7E81);
    #1 check("R10 txd idle", {15'b0, txd}, 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule